// File: doc/BRIEF.md
# Plus-Minus Binary GCD Modular Divider

This block divides one residue by another modulo an odd prime: given X, Y and M it returns Z with Z·Y ≡ X (mod M). It suits a datapath that must avoid multipliers and long comparators. Only additions, subtractions and arithmetic shifts are used. Two value registers, A and B, start from Y and M. Two companion registers, U and V, start from X and 0. At each step A shrinks. U follows every operation done on A, but modulo M. When A reaches zero, B is +1 or −1 and V carries the quotient up to sign.

Loop control follows the bit-length bounds of A and B, so no magnitude comparison is needed. Their difference is kept as a one-hot magnitude with a sign flag. The smaller bound is kept as a one-hot vector that shifts toward bit 0. The run ends when that vector reaches its low end. A step where A is even takes one cycle. A step where both values are odd takes three cycles: parity test, conditional swap, then combine and divide by four. The number of cycles therefore depends on the data.

A caller pulses `start` with the operands present. The caller then waits for the one-cycle `done` pulse and reads `z_out`, which is held until the next result.

Top module: `pm_gcd_divider`

## Requirements
- R1: Out of reset, `done` is 0 and `z_out` is 0.
- R2: For an odd prime M with M mod 4 = 1, 1 ≤ Y < M and 0 ≤ X < M, the `z_out` presented with `done` lies in [0, M) and satisfies Z·Y ≡ X (mod M).
- R3: The same result property holds for odd primes M with M mod 4 = 3, including the largest prime below 2^N.
- R4: With X = 0 and any legal Y, the result is 0.
- R5: With Y = 1 the result equals X. With Y = M−1 the result equals (M−X) mod M.
- R6: `done` is high for exactly one cycle per operation. `z_out` does not change between that pulse and the next accepted start.
- R7: `done` rises no later than 6·N+2 rising clock edges after the edge that samples `start`.
- R8: A `start` pulse that arrives while an operation is in progress is ignored. Exactly one `done` follows, and it carries the result of the first operands.
- R9: With X = Y (nonzero), the result is 1. This includes the smallest moduli 3 and 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Pulse to capture the operands when idle |
| x_in | input | N | Dividend X, below M |
| y_in | input | N | Divisor Y, nonzero and below M |
| m_in | input | N | Odd prime modulus M |
| z_out | output | N | Quotient Z = X / Y mod M |
| done | output | 1 | One-cycle pulse when `z_out` is updated |

## Verification
A wrong companion update, such as the wrong multiple of M added before a shift, breaks Z·Y ≡ X. That error appears at `z_out` on the very next `done`. Errors in the bound vectors show up as termination faults. If a vector stops too early, the result is taken from a B that is not ±1, which yields a wrong quotient. If it stops too late or never moves, the `done` pulse misses the 6·N+2 edge limit. Errors in the swap decision or in the add/subtract choice usually give a wrong quotient as well. Because both M mod 4 classes and the tiny moduli 3 and 5 are covered, each correction branch is driven at least once before a result is compared.

// File: rtl/pm_gcd_pkg.sv
package pm_gcd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TEST,
    ST_SWAP,
    ST_QUAD
  } pm_state_e;
endpackage

// File: rtl/pm_gcd_scale.sv
// Halve or quarter a companion value modulo M: add a multiple of M chosen
// from the low bits and M mod 4, so the shifted-out bits are zero.
module pm_gcd_scale #(
  parameter int W = 35
) (
  input  logic signed [W-1:0] val,
  input  logic        [W-1:0] modulus,
  input  logic                quarter,
  output logic signed [W-1:0] res
);
  logic signed [W-1:0] ms;
  logic signed [W-1:0] adj;
  logic        [1:0]   t;

  always_comb begin
    ms  = $signed(modulus);
    t   = val[1:0] * modulus[1:0];
    adj = val;
    if (!quarter) begin
      if (val[0]) adj = val + ms;
      res = adj >>> 1;
    end else begin
      case (t)
        2'd1:    adj = val - ms;
        2'd2:    adj = val + (ms <<< 1);
        2'd3:    adj = val + ms;
        default: adj = val;
      endcase
      res = adj >>> 2;
    end
  end
endmodule

// File: rtl/pm_gcd_bounds.sv
// Bound tracking: delta = alpha - beta as sign flag plus one-hot magnitude,
// rho = min(alpha, beta) as a one-hot vector walking toward bit 0.
module pm_gcd_bounds #(
  parameter int N = 32
) (
  input  logic clk,
  input  logic rst_i,
  input  logic load,
  input  logic dec,
  input  logic neg_en,
  output logic delta_neg,
  output logic delta_zero,
  output logic rho_end
);
  logic [N:0] mag_q, mag_d;
  logic [N:0] rho_q, rho_d;
  logic       sgn_q, sgn_d;
  logic       en;

  assign delta_zero = mag_q[0];
  assign delta_neg  = sgn_q & ~mag_q[0];
  assign rho_end    = rho_q[0];
  assign en         = load | dec | neg_en;

  always_comb begin
    mag_d = mag_q;
    sgn_d = sgn_q;
    rho_d = rho_q;
    if (load) begin
      mag_d    = '0;
      mag_d[0] = 1'b1;
      sgn_d    = 1'b0;
      rho_d    = '0;
      rho_d[N] = 1'b1;
    end else if (neg_en) begin
      sgn_d = 1'b0;
    end else if (dec) begin
      if (sgn_q | mag_q[0]) rho_d = rho_q >> 1;
      if (mag_q[0]) begin
        mag_d    = '0;
        mag_d[1] = 1'b1;
        sgn_d    = 1'b1;
      end else if (sgn_q) begin
        mag_d = {mag_q[N-1:0], 1'b0};
      end else begin
        mag_d = mag_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      mag_q <= '0;
      mag_q[0] <= 1'b1;
      sgn_q <= 1'b0;
      rho_q <= '0;
      rho_q[0] <= 1'b1;
    end else if (en) begin
      mag_q <= mag_d;
      sgn_q <= sgn_d;
      rho_q <= rho_d;
    end
  end

  assert_rho_onehot_R7: assert property (@(posedge clk) disable iff (!rst_i)
    $countones(rho_q) == 1);
  assert_delta_onehot_R7: assert property (@(posedge clk) disable iff (!rst_i)
    $countones(mag_q) == 1 && !(sgn_q && mag_q[0]));
  assert_delta_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (dec && sgn_q) |-> !mag_q[N]);
  assert_rho_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_i)
    dec |-> !rho_q[0]);
endmodule

// File: rtl/pm_gcd_divider.sv
module pm_gcd_divider
  import pm_gcd_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] x_in,
  input  logic [N-1:0] y_in,
  input  logic [N-1:0] m_in,
  output logic [N-1:0] z_out,
  output logic         done
);
  localparam int AW = N + 2;
  localparam int UW = N + 3;
  localparam logic signed [AW-1:0] B_POS = AW'(1);
  localparam logic signed [AW-1:0] B_NEG = -B_POS;

  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  pm_state_e state_q, state_d;
  logic signed [AW-1:0] a_q, a_d, b_q, b_d, ab_mix;
  logic signed [UW-1:0] u_q, u_d, v_q, v_d, uv_mix, scaled, fin, mod_s;
  logic [N-1:0] m_q, m_d, z_q, z_d;
  logic [UW-1:0] mod_u;
  logic [1:0] lowsum;
  logic done_d, add_sel, load, dec, neg_en;
  logic delta_neg, delta_zero, rho_end;

  assign mod_u   = {3'b000, m_q};
  assign mod_s   = $signed(mod_u);
  assign lowsum  = a_q[1:0] + b_q[1:0];
  assign add_sel = (lowsum == 2'b00);
  assign ab_mix  = add_sel ? a_q + b_q : a_q - b_q;
  assign uv_mix  = add_sel ? u_q + v_q : u_q - v_q;

  pm_gcd_scale #(.W(UW)) u_scale (
    .val     ((state_q == ST_QUAD) ? uv_mix : u_q),
    .modulus (mod_u),
    .quarter (state_q == ST_QUAD),
    .res     (scaled)
  );

  pm_gcd_bounds #(.N(N)) u_bounds (
    .clk        (clk),
    .rst_i      (rst_i),
    .load       (load),
    .dec        (dec),
    .neg_en     (neg_en),
    .delta_neg  (delta_neg),
    .delta_zero (delta_zero),
    .rho_end    (rho_end)
  );

  always_comb begin
    fin = b_q[AW-1] ? -v_q : v_q;
    if (fin[UW-1]) fin = fin + mod_s;
  end

  always_comb begin
    state_d = state_q;
    a_d = a_q; b_d = b_q; u_d = u_q; v_d = v_q;
    m_d = m_q; z_d = z_q;
    done_d = 1'b0; load = 1'b0; dec = 1'b0; neg_en = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        a_d = $signed({2'b00, y_in});
        b_d = $signed({2'b00, m_in});
        u_d = $signed({3'b000, x_in});
        v_d = '0;
        m_d = m_in;
        load = 1'b1;
        state_d = ST_TEST;
      end
      ST_TEST: begin
        if (rho_end) begin
          z_d = fin[N-1:0];
          done_d = 1'b1;
          state_d = ST_IDLE;
        end else if (!a_q[0]) begin
          a_d = a_q >>> 1;
          u_d = scaled;
          dec = 1'b1;
        end else begin
          state_d = ST_SWAP;
        end
      end
      ST_SWAP: begin
        if (delta_neg) begin
          a_d = b_q; b_d = a_q;
          u_d = v_q; v_d = u_q;
          neg_en = 1'b1;
        end
        state_d = ST_QUAD;
      end
      ST_QUAD: begin
        a_d = ab_mix >>> 2;
        u_d = scaled;
        dec = 1'b1;
        state_d = ST_TEST;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_IDLE;
      a_q <= '0; b_q <= B_POS; u_q <= '0; v_q <= '0;
      m_q <= '0; z_q <= '0; done <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
      if (state_q != ST_IDLE || start) begin
        a_q <= a_d; b_q <= b_d; u_q <= u_d; v_q <= v_d; m_q <= m_d;
      end
      if (done_d) z_q <= z_d;
    end
  end

  assign z_out = z_q;

  assert_b_odd_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q != ST_IDLE) |-> b_q[0]);
  assert_quad_exact_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_QUAD) |-> (ab_mix[1:0] == 2'b00 && !delta_neg));
  assert_u_range_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q != ST_IDLE) |-> (u_q > -mod_s && u_q < mod_s && v_q > -mod_s && v_q < mod_s));
  assert_final_unit_R2: assert property (@(posedge clk) disable iff (!rst_i)
    done |-> (b_q == B_POS || b_q == B_NEG) && a_q == '0);
  assert_result_range_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_TEST && rho_end) |-> fin[UW-1:N] == '0);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> !done);
  assert_z_hold_R6: assert property (@(posedge clk) disable iff (!rst_i)
    !done |-> $stable(z_out));
  assert_swap_idle_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q != ST_IDLE && state_q != ST_SWAP) |-> !neg_en);
  assert_delta_zero_quad_R7: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_IDLE) |-> !dec || delta_zero);
endmodule

// File: tb/pm_gcd_divider_bench.sv
`timescale 1ns/1ps
module pm_gcd_divider_bench;
  localparam int N = 32;
  localparam int LAT_MAX = 6 * N + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] x_in = '0, y_in = '0, m_in = '0;
  logic [N-1:0] z_out;
  logic done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pm_gcd_divider #(.N(N)) u_pm_gcd_divider (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_in(x_in), .y_in(y_in), .m_in(m_in),
    .z_out(z_out), .done(done)
  );

  function automatic logic [63:0] mulmod(input logic [63:0] a, input logic [63:0] b,
                                         input logic [63:0] m);
    logic [127:0] p;
    p = {64'd0, a} * {64'd0, b};
    return 64'(p % {64'd0, m});
  endfunction

  function automatic logic [63:0] inv_mod(input logic [63:0] y, input logic [63:0] m);
    logic [63:0] r, base, e;
    r = 64'd1; base = y % m; e = m - 64'd2;
    for (int i = 0; i < 64; i++) begin
      if (e[0]) r = mulmod(r, base, m);
      base = mulmod(base, base, m);
      e = e >> 1;
    end
    return r;
  endfunction

  function automatic logic [N-1:0] expect_q(input logic [N-1:0] x, input logic [N-1:0] y,
                                            input logic [N-1:0] m);
    return N'(mulmod({32'd0, x}, inv_mod({32'd0, y}, {32'd0, m}), {32'd0, m}));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [N-1:0] x, input logic [N-1:0] y, input logic [N-1:0] m,
                        input string req, input logic [N-1:0] exp);
    int cnt;
    @(negedge clk);
    x_in = x; y_in = y; m_in = m; start = 1'b1;
    cnt = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      cnt++;
    end while (!done && cnt < LAT_MAX + 20);
    chk(done == 1'b1 && z_out == exp, req, "quotient", {32'd0, z_out}, {32'd0, exp});
    chk(cnt <= LAT_MAX, "R7", "latency", cnt, LAT_MAX);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] primes [9];
    logic [N-1:0] m, x, y, zs, e1;
    int seen;
    primes[0] = 32'hFFFFFFFB; primes[1] = 32'd2147483647; primes[2] = 32'd1000000007;
    primes[3] = 32'd7;        primes[4] = 32'd3;          primes[5] = 32'd998244353;
    primes[6] = 32'd65521;    primes[7] = 32'd13;         primes[8] = 32'd5;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    chk(done == 1'b0 && z_out == '0, "R1", "reset outputs", {31'd0, done, z_out}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done == 1'b0 && z_out == '0, "R1", "after release", {31'd0, done, z_out}, 0);

    // random operands across both M mod 4 classes
    for (int p = 0; p < 9; p++) begin
      m = primes[p];
      for (int k = 0; k < 6; k++) begin
        y = 1 + ($urandom % (m - 1));
        x = $urandom % m;
        run_op(x, y, m, (m[1:0] == 2'b01) ? "R2" : "R3", expect_q(x, y, m));
      end
    end

    // directed corners
    for (int p = 0; p < 9; p++) begin
      m = primes[p];
      x = $urandom % m;
      y = 1 + ($urandom % (m - 1));
      run_op('0, y, m, "R4", '0);
      run_op(x, 1, m, "R5", x);
      run_op(x, m - 1, m, "R5", (x == '0) ? '0 : m - x);
      if (x == '0) x = 1;
      run_op(x, x, m, "R9", 1);
    end
    run_op(32'hFFFFFFFA, 32'hFFFFFFFA, 32'hFFFFFFFB, "R9", 1);
    run_op(32'hFFFFFFFA, 32'd2, 32'hFFFFFFFB, "R3", expect_q(32'hFFFFFFFA, 32'd2, 32'hFFFFFFFB));

    // R6: single pulse and held result
    zs = z_out;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(done == 1'b0 && z_out == zs, "R6", "hold after done", {32'd0, z_out}, {32'd0, zs});
    end

    // R8: start while busy is ignored
    e1 = expect_q(32'd123456789, 32'd987654321, 32'd2147483647);
    @(negedge clk);
    x_in = 32'd123456789; y_in = 32'd987654321; m_in = 32'd2147483647; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    x_in = 32'd5; y_in = 32'd3; m_in = 32'd7; start = 1'b1;
    @(negedge clk); start = 1'b0;
    seen = 0;
    for (int i = 0; i < LAT_MAX + 10; i++) begin
      if (done) begin
        seen++;
        chk(z_out == e1, "R8", "first operands kept", {32'd0, z_out}, {32'd0, e1});
      end
      @(negedge clk);
    end
    chk(seen == 1, "R8", "done count", seen, 1);
    run_op(32'd5, 32'd3, 32'd7, "R8", expect_q(32'd5, 32'd3, 32'd7));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule